// File: doc/BRIEF.md
# Packed SIMD Lane Comparator

This block compares two 128-bit packed vectors lane by lane and returns a per-lane mask. Each result lane is all ones of its width when the lane of the first operand compares true against the matching lane of the second operand, and all zeros otherwise. The lanes can be signed integers, unsigned integers or single-precision floats, and the test can be greater-or-equal or strictly greater.

The operation is taken from a 32-bit instruction word. The block decodes only the bits that select the compare kind, the lane width and the test. A separate input chooses signed or unsigned integer lanes. A request is presented with `start` high for one cycle. The registered response appears on the next clock edge: `res_valid` pulses for one cycle, with the mask on `res` and `res_illegal` set when the encoding is not supported.

Top module: `simd_lane_cmp`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `res_valid`, `res_illegal` and `res` to zero.
- R2: Each cycle with `start` high causes `res_valid` to be high for exactly the following cycle. A cycle without `start` causes `res_valid` to be low in the following cycle.
- R3: The instruction selects an integer compare when `insn[11:8]` is 4'h3. Within that encoding, `insn[4]`=1 selects greater-or-equal and `insn[4]`=0 selects strictly greater. `insn[21:20]` sets the lane width: 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes and 2 gives four 32-bit lanes.
- R4: Lane i of `res` covers bits [i*W +: W] for lane width W. It compares `opa` lane i against `opb` lane i. The lane is all ones of width W when the test is true and zero when it is false.
- R5: `is_signed`=1 reads integer lanes as two's complement and `is_signed`=0 reads them as unsigned. For example, the 8-bit values 8'h80 and 8'h01 give 8'h80 > 8'h01 only when unsigned.
- R6: The instruction selects a float compare when `insn[20]`=0, `insn[11:8]`=4'hE and `insn[4]`=0. Within that encoding, `insn[21]`=0 selects greater-or-equal and `insn[21]`=1 selects strictly greater. Float compares always use four 32-bit IEEE single-precision lanes, and `is_signed` has no effect on them.
- R7: In a float compare, a lane that holds a NaN in either operand gives zero for both tests.
- R8: In a float compare, +0.0 and -0.0 are equal. Infinities order above and below all finite values, and denormals compare by their value.
- R9: An integer compare with lane-width code 3 is illegal. The response has `res_valid` and `res_illegal` set and `res` equal to zero.
- R10: Any instruction that matches neither the integer encoding nor the float encoding is illegal and responds in the same way as in R9.
- R11: When both operands hold equal lanes, greater-or-equal yields all ones in those lanes and strictly greater yields zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, one cycle per compare |
| insn | input | 32 | Instruction word holding the compare encoding |
| opa | input | 128 | First source vector |
| opb | input | 128 | Second source vector |
| is_signed | input | 1 | Integer lanes are two's complement when high |
| res | output | 128 | Registered lane mask |
| res_valid | output | 1 | Response strobe, one cycle after `start` |
| res_illegal | output | 1 | Request encoding was not supported |

## Verification
The assertions assume that `insn`, `opa`, `opb` and `is_signed` are stable when sampled at the edge where `start` is high. They also assume that reset is held long enough for the first edge to clear the response registers. The bench drives all request inputs on the falling edge and drops `start` after one cycle, so every sampled request is a clean single-cycle pulse. It reads the response on the following falling edge. The bench steers operand values toward sign boundaries, equal lanes, NaN, infinities, signed zeros and denormals, where a wrong interpretation changes the mask.

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   insn,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          is_signed,
  output logic [DW-1:0] res,
  output logic          res_valid,
  output logic          res_illegal
);
  localparam int NW = DW / 32;
  localparam int NB = DW / 8;
  localparam int NH = DW / 16;

  logic       op_int, op_flt, illegal, int_ge, flt_ge;
  logic [1:0] lsz;

  assign lsz     = insn[21:20];
  assign op_int  = insn[11:8] == 4'h3;
  assign op_flt  = insn[11:8] == 4'hE && !insn[20] && !insn[4];
  assign illegal = !(op_int || op_flt) || (op_int && lsz == 2'd3);
  assign int_ge  = insn[4];
  assign flt_ge  = !insn[21];

  logic unused_bits;
  assign unused_bits = ^{insn[31:22], insn[19:12], insn[7:5], insn[3:0]};

  logic [NB-1:0] hit8;
  logic [NH-1:0] hit16;
  logic [NW-1:0] hit32, fhit;

  function automatic logic [31:0] fkey(input logic [31:0] x);
    return x[31] ? ~x : {1'b1, x[30:0]};
  endfunction

  for (genvar b = 0; b < NB; b++) begin : g_b8
    logic [7:0] ka, kb;
    assign ka = {opa[8*b+7] ^ is_signed, opa[8*b +: 7]};
    assign kb = {opb[8*b+7] ^ is_signed, opb[8*b +: 7]};
    assign hit8[b] = int_ge ? (ka >= kb) : (ka > kb);
  end

  for (genvar h = 0; h < NH; h++) begin : g_b16
    logic [15:0] ka, kb;
    assign ka = {opa[16*h+15] ^ is_signed, opa[16*h +: 15]};
    assign kb = {opb[16*h+15] ^ is_signed, opb[16*h +: 15]};
    assign hit16[h] = int_ge ? (ka >= kb) : (ka > kb);
  end

  for (genvar w = 0; w < NW; w++) begin : g_b32
    logic [31:0] ka, kb, fa, fb, xa, xb;
    logic        nan_a, nan_b, zz;
    assign ka = {opa[32*w+31] ^ is_signed, opa[32*w +: 31]};
    assign kb = {opb[32*w+31] ^ is_signed, opb[32*w +: 31]};
    assign hit32[w] = int_ge ? (ka >= kb) : (ka > kb);

    assign xa    = opa[32*w +: 32];
    assign xb    = opb[32*w +: 32];
    assign nan_a = &xa[30:23] && |xa[22:0];
    assign nan_b = &xb[30:23] && |xb[22:0];
    assign zz    = xa[30:0] == 31'd0 && xb[30:0] == 31'd0;
    assign fa    = fkey(xa);
    assign fb    = fkey(xb);
    assign fhit[w] = !(nan_a || nan_b) &&
                     (zz ? flt_ge : (flt_ge ? (fa >= fb) : (fa > fb)));
  end

  logic [DW-1:0] mask;
  for (genvar j = 0; j < NB; j++) begin : g_mask
    logic sel;
    always_comb begin
      if (op_flt)            sel = fhit[j/4];
      else if (lsz == 2'd0)  sel = hit8[j];
      else if (lsz == 2'd1)  sel = hit16[j/2];
      else                   sel = hit32[j/4];
    end
    assign mask[8*j +: 8] = {8{sel}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res         <= '0;
      res_valid   <= 1'b0;
      res_illegal <= 1'b0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_illegal <= illegal;
        res         <= illegal ? '0 : mask;
      end
    end
  end
endmodule

module simd_lane_cmp_chk #(
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [31:0]   insn,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic          is_signed,
  input logic [DW-1:0] res,
  input logic          res_valid,
  input logic          res_illegal
);
  p_valid_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_valid);
  p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !res_valid);
  p_size3_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && insn[11:8] == 4'h3 && insn[21:20] == 2'd3) |=> (res_illegal && res == '0));
  p_unknown_op_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && insn[11:8] != 4'h3 && insn[11:8] != 4'hE) |=> (res_illegal && res == '0));
  p_eq_gt_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opa == opb && insn[11:8] == 4'h3 && !insn[4] && insn[21:20] != 2'd3) |=> res == '0);
  p_eq_ge_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opa == opb && insn[11:8] == 4'h3 && insn[4] && insn[21:20] != 2'd3) |=> res == '1);
  p_word_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && insn[11:8] == 4'h3 && insn[21:20] == 2'd2) |=> (res[31:0] == 32'd0 || res[31:0] == '1));
  p_legal_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && insn[11:8] == 4'h3 && insn[21:20] != 2'd3) |=> !res_illegal);
endmodule

bind simd_lane_cmp simd_lane_cmp_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_simd_lane_cmp.sv
module tb_simd_lane_cmp;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] opa = '0, opb = '0;
  logic         is_signed = 1'b0;
  logic [127:0] res;
  logic         res_valid, res_illegal;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  simd_lane_cmp dut (.clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
    .opa(opa), .opb(opb), .is_signed(is_signed), .res(res),
    .res_valid(res_valid), .res_illegal(res_illegal));

  function automatic logic [31:0] mk_int(input logic [1:0] sz, input logic ge);
    return 32'h0000_0300 | (32'(sz) << 20) | (32'(ge) << 4);
  endfunction
  function automatic logic [31:0] mk_flt(input logic gt);
    return 32'h0000_0E00 | (32'(gt) << 21);
  endfunction

  function automatic void fcmp(input logic [31:0] x, input logic [31:0] y,
                               output logic gt, output logic eq);
    logic nx, ny;
    nx = &x[30:23] && |x[22:0];
    ny = &y[30:23] && |y[22:0];
    gt = 0; eq = 0;
    if (nx || ny) return;
    if (x[30:0] == 0 && y[30:0] == 0) begin eq = 1; return; end
    if (x == y) begin eq = 1; return; end
    if (x[31] != y[31]) gt = !x[31];
    else if (!x[31]) gt = x[30:0] > y[30:0];
    else gt = x[30:0] < y[30:0];
  endfunction

  function automatic logic [127:0] model(input logic [31:0] ins, input logic [127:0] a,
      input logic [127:0] b, input logic sg, output logic ill);
    logic [127:0] r, ones;
    r = '0; ones = '1; ill = 1;
    if (ins[11:8] == 4'h3 && ins[21:20] != 2'd3) begin
      int w;
      ill = 0;
      w = 8 << ins[21:20];
      for (int i = 0; i < 128 / w; i++) begin
        longint ea, eb;
        logic t;
        ea = longint'((a >> (i * w)) & (ones >> (128 - w)));
        eb = longint'((b >> (i * w)) & (ones >> (128 - w)));
        if (sg && ea >= (64'sd1 << (w - 1))) ea = ea - (64'sd1 << w);
        if (sg && eb >= (64'sd1 << (w - 1))) eb = eb - (64'sd1 << w);
        t = ins[4] ? (ea >= eb) : (ea > eb);
        if (t) r = r | ((ones >> (128 - w)) << (i * w));
      end
    end else if (ins[11:8] == 4'hE && !ins[20] && !ins[4]) begin
      ill = 0;
      for (int i = 0; i < 4; i++) begin
        logic gt, eq;
        fcmp(a[32*i +: 32], b[32*i +: 32], gt, eq);
        if (ins[21] ? gt : (gt || eq)) r[32*i +: 32] = '1;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [31:0] ins, input logic [127:0] a,
                     input logic [127:0] b, input logic sg);
    logic [127:0] e;
    logic ill;
    e = model(ins, a, b, sg, ill);
    @(negedge clk);
    insn = ins; opa = a; opb = b; is_signed = sg; start = 1;
    @(negedge clk);
    start = 0;
    check({req, " valid"}, 128'(res_valid), 128'd1);
    check({req, " illegal"}, 128'(res_illegal), 128'(ill));
    check({req, " result"}, res, e);
  endtask

  task automatic t_reset;
    check("R1 valid", 128'(res_valid), 128'd0);
    check("R1 illegal", 128'(res_illegal), 128'd0);
    check("R1 result", res, 128'd0);
  endtask

  task automatic t_pulse;
    run("R2 req", mk_int(2'd0, 1'b1), '0, '0, 1'b0);
    @(negedge clk);
    check("R2 drop", 128'(res_valid), 128'd0);
  endtask

  task automatic t_signedness;
    logic [127:0] a, b;
    a = {16{8'h80}}; b = {16{8'h01}};
    run("R5 u8 gt", mk_int(2'd0, 1'b0), a, b, 1'b0);
    check("R5 u8 ones", res, '1);
    run("R5 s8 gt", mk_int(2'd0, 1'b0), a, b, 1'b1);
    check("R5 s8 zero", res, '0);
    a = {8{16'h7FFF}}; b = {8{16'h8000}};
    run("R5 s16 max/min", mk_int(2'd1, 1'b0), a, b, 1'b1);
    run("R5 u16 max/min", mk_int(2'd1, 1'b0), a, b, 1'b0);
    a = {32'hFFFF_FFFF, 32'h0, 32'h8000_0000, 32'h7FFF_FFFF};
    b = {32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
    run("R5 s32 edge", mk_int(2'd2, 1'b1), a, b, 1'b1);
    run("R5 u32 edge", mk_int(2'd2, 1'b1), a, b, 1'b0);
  endtask

  task automatic t_lanes;
    logic [127:0] a, b;
    a = 128'h00FF_1234_8000_0001_7F7F_0000_FFFF_0102;
    b = 128'h0100_1234_7FFF_0002_7F80_0000_FFFE_0201;
    for (int sz = 0; sz < 3; sz++) begin
      run("R3 R4 ge", mk_int(2'(sz), 1'b1), a, b, 1'b1);
      run("R3 R4 gt", mk_int(2'(sz), 1'b0), a, b, 1'b0);
    end
  endtask

  task automatic t_equal;
    logic [127:0] a;
    a = 128'h8000_7FFF_0000_FFFF_1234_5678_9ABC_DEF0;
    run("R11 eq ge", mk_int(2'd0, 1'b1), a, a, 1'b1);
    check("R11 ge ones", res, '1);
    run("R11 eq gt", mk_int(2'd2, 1'b0), a, a, 1'b0);
    check("R11 gt zero", res, '0);
  endtask

  task automatic t_float;
    logic [127:0] a, b;
    a = {32'h7FC0_0000, 32'h0000_0000, 32'h7F80_0000, 32'h8000_0001};
    b = {32'h3F80_0000, 32'h8000_0000, 32'h7F7F_FFFF, 32'h8000_0002};
    run("R6 R7 R8 ge", mk_flt(1'b0), a, b, 1'b0);
    check("R8 ge lanes", res, {32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF});
    run("R6 R7 R8 gt", mk_flt(1'b1), a, b, 1'b1);
    check("R8 gt lanes", res, {32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF});
    a = {32'hFF80_0000, 32'h3F80_0000, 32'h0000_0001, 32'h3F80_0000};
    b = {32'hFF7F_FFFF, 32'hFFC0_0001, 32'h8000_0000, 32'hBF80_0000};
    run("R7 R8 mix ge", mk_flt(1'b0), a, b, 1'b0);
    check("R7 nan lane", res, {32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF});
  endtask

  task automatic t_illegal;
    logic [127:0] a;
    a = {4{32'h1234_5678}};
    run("R9 size3 ge", mk_int(2'd3, 1'b1), a, '0, 1'b0);
    check("R9 zero", res, '0);
    run("R10 opc 8", 32'h0000_0810, a, '0, 1'b0);
    run("R10 flt bit4", mk_flt(1'b0) | 32'h10, a, '0, 1'b0);
    run("R10 flt bit20", mk_flt(1'b0) | 32'h0010_0000, a, '0, 1'b0);
    check("R10 zero", res, '0);
  endtask

  task automatic t_random;
    for (int n = 0; n < 300; n++) begin
      logic [127:0] a, b;
      logic [31:0] ins;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if (n % 4 == 0) b = (a & {$urandom, $urandom, $urandom, $urandom}) | (b & 128'hFF00_00FF_0000_FFFF_00FF_0F0F_0000_F0F0);
      if (n % 3 == 0) ins = mk_flt(1'($urandom));
      else ins = mk_int(2'($urandom % 3), 1'($urandom));
      run("R4 random", ins, a, b, 1'($urandom));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_pulse();
    t_signedness();
    t_lanes();
    t_equal();
    t_float();
    t_illegal();
    t_random();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule